// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Fabric

This block is a configurable two-level logic fabric that behaves like a fuse-programmed logic array. A bank of product-term AND gates sees every input both in true and in complemented form, and each of those literals has its own fuse. An OR stage merges product terms into outputs, and each output then passes through an XOR with a per-output inversion fuse. This allows a function to be built from its zeros and then flipped back to true polarity. A fuse value of 1 means intact, and an intact fuse applies its literal. A term with all of its fuses intact therefore ANDs a literal with its own complement and is always 0.

The elaboration parameter `PAL_MODE` selects between two structures. With `PAL_MODE = 1`, the OR stage is hard-wired: output o is the OR of product terms 3o, 3o+1 and 3o+2. With `PAL_MODE = 0`, the OR stage has its own fuses, so any term can feed any number of outputs. The configuration arrives one bit per clock on a serial chain while the commit strobe is low. A single clock with the strobe high copies the chain into the active fuse map. The outputs are purely combinational from the inputs and the active map.

Top module: `sop_fabric`

## Requirements
- R1: After reset every fuse is intact and every inversion bit is 0, so with every input pattern all outputs are 0.
- R2: A product term whose fuses are all intact contributes 0 to every output, whatever the inputs are.
- R3: For each term and input, the pair (true fuse, complement fuse) works as follows: (1,0) requires the input to be 1, (0,1) requires it to be 0, and (0,0) makes the input a don't-care. A term with every pair at (0,0) is constantly 1.
- R4: Bit p sent on the chain (p = 0 first) is placed as follows. For p < 2·N_IN·N_TERM it is an AND fuse with term t = p / (2·N_IN), input i = (p mod 2·N_IN) / 2, and complement when p is odd. The next N_OUT·N_TERM bits are OR fuses, with output = q / N_TERM and term = q mod N_TERM, where q is the offset into that section. The last N_OUT bits are the inversion bits of outputs 0 to N_OUT-1.
- R5: While the commit strobe is low, bits shift in and the outputs keep following the previously committed map. The new map takes effect once the clock edge that samples the strobe high has occurred.
- R6: An inversion bit of 1 complements its output, and 0 passes the sum-of-products through unchanged.
- R7: With PAL_MODE = 1, output o is the OR of terms 3o to 3o+2, and the OR-fuse bits on the chain have no effect.
- R8: With PAL_MODE = 0, output o includes term t exactly when its OR fuse (o, t) is 1, and one term may feed several outputs.
- R9: An input change reaches the outputs without any clock edge.
- R10: While the commit strobe is high the chain holds its contents, so holding the strobe high for several cycles commits the same map again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset to the unprogrammed map |
| cfg_din | input | 1 | Serial configuration bit |
| cfg_commit | input | 1 | High: copy chain to active map; low: shift chain |
| in_vec | input | N_IN | Logic inputs; bit 3 is the most significant variable of a minterm index |
| out_vec | output | N_OUT | Logic outputs |

## Verification
The bench programs both fabric variants with four functions of four variables and compares every one of the 16 minterms against truth-table masks. In the array form, a fourth function reuses the two product terms of the first. A design with the true and complement fuses swapped, or with the chain order reversed, produces scrambled functions. A design where all-intact gates float to 1 makes idle outputs read 1. A design that shifts while committing, or that lets the chain drive the outputs directly, shows wrong values after a repeated commit or during a shift. Setting every OR fuse in the fixed-group form would expose a design that wrongly consults those bits.

// File: rtl/sop_fabric.sv
module sop_fabric #(
  parameter int N_IN     = 4,
  parameter int N_OUT    = 4,
  parameter int N_TERM   = 12,
  parameter bit PAL_MODE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_din,
  input  logic              cfg_commit,
  input  logic [N_IN-1:0]   in_vec,
  output logic [N_OUT-1:0]  out_vec
);
  localparam int GROUP    = 3;
  localparam int FUSE_W   = 2 * N_IN;
  localparam int AND_BITS = N_TERM * FUSE_W;
  localparam int OR_BITS  = N_OUT * N_TERM;
  localparam int CHAIN    = AND_BITS + OR_BITS + N_OUT;

  logic [CHAIN-1:0]    chain_q;
  logic [AND_BITS-1:0] and_q;
  logic [N_OUT-1:0]    inv_q;
  logic [N_TERM-1:0]   term;
  logic [N_OUT-1:0]    sop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {{(AND_BITS + OR_BITS){1'b1}}, {N_OUT{1'b0}}};
      and_q   <= '1;
      inv_q   <= '0;
    end else if (cfg_commit) begin
      and_q <= chain_q[CHAIN-1 -: AND_BITS];
      inv_q <= chain_q[N_OUT-1:0];
    end else begin
      chain_q <= {chain_q[CHAIN-2:0], cfg_din};
    end
  end

  // R5
  map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_commit |=> ($stable(and_q) && $stable(inv_q)));

  // R10
  chain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_commit |=> $stable(chain_q));

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [FUSE_W-1:0] fz;
    logic [N_IN-1:0]   ok;
    assign fz = and_q[AND_BITS-1-t*FUSE_W -: FUSE_W];
    for (genvar i = 0; i < N_IN; i++) begin : g_lit
      assign ok[i] = (~fz[FUSE_W-1-2*i] | in_vec[i]) & (~fz[FUSE_W-2-2*i] | ~in_vec[i]);
    end
    assign term[t] = &ok;

    // R2
    dead_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&fz) |-> !term[t]);
  end

  if (PAL_MODE) begin : g_fixed
    for (genvar o = 0; o < N_OUT; o++) begin : g_grp
      assign sop[o] = |term[GROUP*o +: GROUP];
    end
  end else begin : g_prog
    logic [OR_BITS-1:0] or_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          or_q <= '1;
      else if (cfg_commit) or_q <= chain_q[N_OUT +: OR_BITS];
    end
    for (genvar o = 0; o < N_OUT; o++) begin : g_out
      logic [N_TERM-1:0] sel;
      for (genvar t = 0; t < N_TERM; t++) begin : g_sel
        assign sel[t] = term[t] & or_q[OR_BITS-1-o*N_TERM-t];
      end
      assign sop[o] = |sel;
    end
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_pol
    assign out_vec[o] = sop[o] ^ inv_q[N_OUT-1-o];

    // R6
    idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (term == '0) |-> (out_vec[o] == inv_q[N_OUT-1-o]));
  end
endmodule

// File: tb/sop_fabric_tb.sv
`timescale 1ns/1ps
module sop_fabric_tb;
  localparam int NI = 4, NO = 4, NT = 12;
  localparam int ANDB = NT * 2 * NI;
  localparam int ORB  = NO * NT;
  localparam int LEN  = ANDB + ORB + NO;

  logic clk = 1'b0, rst_n = 1'b0, cfg_din = 1'b0, cfg_commit = 1'b1;
  logic [NI-1:0] in_vec = '0;
  logic [NO-1:0] pal_out, pla_out;
  logic [LEN-1:0] cfg;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  sop_fabric #(.N_IN(NI), .N_OUT(NO), .N_TERM(NT), .PAL_MODE(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_din(cfg_din), .cfg_commit(cfg_commit),
    .in_vec(in_vec), .out_vec(pal_out));

  sop_fabric #(.N_IN(NI), .N_OUT(NO), .N_TERM(NT), .PAL_MODE(1'b0)) u_pla (
    .clk(clk), .rst_n(rst_n), .cfg_din(cfg_din), .cfg_commit(cfg_commit),
    .in_vec(in_vec), .out_vec(pla_out));

  task automatic note(input string tag, input logic [NO-1:0] got, input logic [NO-1:0] exp, input int m);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s m=%0d actual=%b expected=%b", tag, m, got, exp);
    end
  endtask

  task automatic check_all(input string tag, input bit pla, input logic [15:0] f0,
                           input logic [15:0] f1, input logic [15:0] f2, input logic [15:0] f3);
    for (int m = 0; m < 16; m++) begin
      @(negedge clk);
      in_vec = m[NI-1:0];
      #1;
      note(tag, pla ? pla_out : pal_out, {f3[m], f2[m], f1[m], f0[m]}, m);
    end
  endtask

  task automatic clear_cfg();
    cfg = '0;
    for (int p = 0; p < ANDB; p++) cfg[p] = 1'b1;
  endtask

  task automatic put_term(input int t, input string pat);
    for (int k = 0; k < NI; k++) begin
      int b;
      b = t * 2 * NI + 2 * (NI - 1 - k);
      if (pat[k] == "1")      begin cfg[b] = 1'b1; cfg[b+1] = 1'b0; end
      else if (pat[k] == "0") begin cfg[b] = 1'b0; cfg[b+1] = 1'b1; end
      else                    begin cfg[b] = 1'b0; cfg[b+1] = 1'b0; end
    end
  endtask

  task automatic link(input int o, input int t);
    cfg[ANDB + o * NT + t] = 1'b1;
  endtask

  task automatic invert(input int o);
    cfg[ANDB + ORB + o] = 1'b1;
  endtask

  task automatic shift_cfg();
    for (int p = 0; p < LEN; p++) begin
      @(negedge clk);
      cfg_commit = 1'b0;
      cfg_din = cfg[p];
    end
  endtask

  task automatic commit_cfg(input int cycles);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      cfg_commit = 1'b1;
      cfg_din = ~cfg_din;
    end
    @(negedge clk);
    cfg_commit = 1'b0;
  endtask

  task automatic example_fixed();
    clear_cfg();
    put_term(0, "110-"); put_term(1, "0010");
    put_term(3, "1---"); put_term(4, "-111");
    put_term(6, "01--"); put_term(7, "-0-0"); put_term(8, "--11");
    put_term(9, "1---"); put_term(10, "-111");
    invert(3);
  endtask

  task automatic test_reset();
    check_all("R1 fixed", 1'b0, 16'h0, 16'h0, 16'h0, 16'h0);
    check_all("R1 array", 1'b1, 16'h0, 16'h0, 16'h0, 16'h0);
  endtask

  task automatic test_literals();
    clear_cfg();
    put_term(0, "1---"); put_term(3, "-0--"); put_term(6, "----");
    link(0, 0); link(1, 3); link(2, 6);
    shift_cfg(); commit_cfg(1);
    check_all("R3 R2 fixed", 1'b0, 16'hFF00, 16'h0F0F, 16'hFFFF, 16'h0000);
    check_all("R3 R2 array", 1'b1, 16'hFF00, 16'h0F0F, 16'hFFFF, 16'h0000);
  endtask

  task automatic test_fixed_groups();
    example_fixed();
    shift_cfg(); commit_cfg(1);
    check_all("R7 R4 R6 fixed", 1'b0, 16'h3004, 16'hFF80, 16'h8DFD, 16'h007F);
    check_all("R8 array unlinked", 1'b1, 16'h0, 16'h0, 16'h0, 16'hFFFF);
    for (int p = ANDB; p < ANDB + ORB; p++) cfg[p] = 1'b1;
    shift_cfg(); commit_cfg(1);
    check_all("R7 or bits ignored", 1'b0, 16'h3004, 16'hFF80, 16'h8DFD, 16'h007F);
  endtask

  task automatic test_comb();
    @(posedge clk);
    #0.5 in_vec = 4'b1100;
    #1 note("R9 no edge", pal_out, 4'b0011, 12);
    in_vec = 4'b0111;
    #1 note("R9 no edge", pal_out, 4'b0110, 7);
  endtask

  task automatic test_shared();
    clear_cfg();
    put_term(0, "110-"); put_term(1, "0010"); put_term(2, "0001");
    put_term(3, "1---"); put_term(4, "-111"); put_term(5, "1-00");
    put_term(6, "01--"); put_term(7, "-0-0"); put_term(8, "--11");
    link(0, 0); link(0, 1);
    link(1, 3); link(1, 4);
    link(2, 6); link(2, 7); link(2, 8);
    link(3, 0); link(3, 1); link(3, 2); link(3, 5);
    shift_cfg(); commit_cfg(1);
    check_all("R8 shared terms", 1'b1, 16'h3004, 16'hFF80, 16'h8DFD, 16'h3106);
    invert(0);
    shift_cfg(); commit_cfg(1);
    check_all("R6 array invert", 1'b1, 16'hCFFB, 16'hFF80, 16'h8DFD, 16'h3106);
  endtask

  task automatic test_shadow();
    clear_cfg();
    shift_cfg();
    check_all("R5 during shift", 1'b1, 16'hCFFB, 16'hFF80, 16'h8DFD, 16'h3106);
    commit_cfg(1);
    check_all("R5 after commit", 1'b1, 16'h0, 16'h0, 16'h0, 16'h0);
  endtask

  task automatic test_commit_hold();
    example_fixed();
    shift_cfg(); commit_cfg(4);
    check_all("R10 long commit", 1'b0, 16'h3004, 16'hFF80, 16'h8DFD, 16'h007F);
  endtask

  initial begin
    #(200000 * 8);
    checks++; errors++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_literals();
    test_fixed_groups();
    test_comb();
    test_shared();
    test_shadow();
    test_commit_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule